// File: doc/BRIEF.md
# Flow-Through Zero-Idle Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static memory. It can switch between reads and writes on back-to-back clock edges with no dead cycle. Each word is made of four byte lanes, and every lane can carry an optional parity bit. The depth is a parameter and is kept small.

An access begins on an edge where `load_n` is low. On that edge the block samples three select lines, the read/write choice, the address and the lane enables. For a read, the stored word is presented combinationally right after that same edge; there is no second output register. For a write, the data arrives one active cycle later and is stored on the following enabled edge. The memory therefore sees a read and a write on consecutive edges without a bubble.

Edges where `load_n` is high continue the current access. They step the two low address bits and wrap within a group of four. A high `stall` makes the block ignore the edge completely. A high `sleep` blocks every input and turns the output drive off, while the stored contents are kept. The data pins come out as a plain in/out/enable triple with no flow control: a word is offered on every active cycle and the block never applies back-pressure. The control pins are plain levels.

Top module: `fts_sram`

## Requirements
- R1: After reset, no access is in progress and `rdata_en` is low.
- R2: After an enabled edge that loads a read, `rdata` equals the stored word at that address within the same cycle, and `rdata_en` is high while `drive_n` is low.
- R3: The write data on `wdata` during the cycle after an enabled edge that loaded or continued a write is stored on the next enabled edge. A read loaded on that same edge at the same address returns the new word.
- R4: Lane i occupies bits [9i+8:9i] of the word, with parity as bit 9i+8 when present. A low `lane_wr_n[i]`, sampled with the write address, stores lane i. A lane whose enable is high keeps its old contents.
- R5: On an edge with `load_n` high, `write_n` is ignored and the access keeps the read or write type of the last loaded address.
- R6: On an edge with `load_n` high, the address advances by one in its two low bits, wrapping 3 to 0, and the upper bits are unchanged.
- R7: `sel_a_n`, `sel_b` and `sel_c_n` are sampled only when `load_n` is low. If any of them is inactive at that point, the access is a deselect: nothing is driven and nothing is written, including on the edges that continue it.
- R8: While `stall` is high, clock edges have no effect: the pending write, the address and the output data all hold.
- R9: While `sleep` is high, all other inputs are ignored, `rdata_en` is low at once, and the stored contents are retained.
- R10: A high `drive_n` forces `rdata_en` low without changing any internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| stall | input | 1 | High: ignore the clock edge |
| sleep | input | 1 | High: asynchronous low-power hold |
| load_n | input | 1 | Low: load new address; high: continue burst |
| write_n | input | 1 | Low: write, high: read (sampled at load) |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| drive_n | input | 1 | Asynchronous output drive enable, active low |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data (late by one active cycle) |
| rdata | output | 36 | Read data |
| rdata_en | output | 1 | Output drive enable for `rdata` |

## Verification
The case that matters most is a single enabled edge that both stores a pending write and registers a new read of the same address. The bench provokes it by loading a read directly after a write, and again after a write burst whose last beat is still pending. It then compares `rdata` in the very next cycle against the freshly written or lane-merged word. A stall placed between a write address and its data also makes the commit and the next read share one edge once the stall is released, and the bench checks that this read returns the data present on that final edge.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int AW         = 6,
  parameter int LANES      = 4,
  parameter int BURST_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             sleep,
  input  logic             load_n,
  input  logic             write_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] lanes_q,
  output logic             commit
);
  logic          adv;
  logic          sel_ok;
  op_e           op_d;
  logic [AW-1:0] addr_d;

  assign adv    = !stall && !sleep;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign commit = adv && (op_q == OP_WRITE);

  always_comb begin
    if (!load_n) begin
      if (!sel_ok)      op_d = OP_IDLE;
      else if (write_n) op_d = OP_READ;
      else              op_d = OP_WRITE;
      addr_d = addr;
    end else begin
      op_d   = op_q;
      addr_d = {addr_q[AW-1:BURST_BITS],
                addr_q[BURST_BITS-1:0] + BURST_BITS'(1)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      lanes_q <= '0;
    end else if (adv) begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      lanes_q <= ~lane_wr_n;
    end
  end

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || sleep) |=> ($stable(op_q) && $stable(addr_q) && $stable(lanes_q))); // R8
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !sleep && load_n) |=>
      ((addr_q[BURST_BITS-1:0] == $past(addr_q[BURST_BITS-1:0]) + BURST_BITS'(1)) &&
       $stable(addr_q[AW-1:BURST_BITS]))); // R6
  AST_TYPE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !sleep && load_n) |=> $stable(op_q)); // R5
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !sleep && !load_n && (sel_a_n || !sel_b || sel_c_n)) |=> (op_q == OP_IDLE)); // R7
endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wlanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlanes[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter bit PARITY = 1'b1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          stall,
  input  logic                                          sleep,
  input  logic                                          load_n,
  input  logic                                          write_n,
  input  logic                                          sel_a_n,
  input  logic                                          sel_b,
  input  logic                                          sel_c_n,
  input  logic [LANES-1:0]                              lane_wr_n,
  input  logic                                          drive_n,
  input  logic [ADDR_W-1:0]                             addr,
  input  logic [LANES*(BYTE_W+(PARITY ? 1 : 0))-1:0]    wdata,
  output logic [LANES*(BYTE_W+(PARITY ? 1 : 0))-1:0]    rdata,
  output logic                                          rdata_en
);
  localparam int LANE_W = BYTE_W + (PARITY ? 1 : 0);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic              commit;
  logic [DATA_W-1:0] arr_q;

  fts_ctrl #(.AW(ADDR_W), .LANES(LANES), .BURST_BITS(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep),
    .load_n(load_n), .write_n(write_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .lane_wr_n(lane_wr_n), .addr(addr),
    .op_q(op_q), .addr_q(addr_q), .lanes_q(lanes_q), .commit(commit)
  );

  fts_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(commit), .waddr(addr_q), .wlanes(lanes_q),
    .wdata(wdata), .raddr(addr_q), .rdata(arr_q)
  );

  assign rdata    = arr_q;
  assign rdata_en = (op_q == OP_READ) && !drive_n && !sleep;

  AST_SLEEP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !commit); // R9
  AST_STALL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !commit); // R8
endmodule

// File: tb/tb_fts_sram.sv
module tb_fts_sram;
  typedef struct packed {
    logic        load_n;
    logic        write_n;
    logic        sel;
    logic [3:0]  bw_n;
    logic [5:0]  addr;
    logic [35:0] wdata;
    logic        exp_en;
    logic [35:0] exp_d;
  } vec_t;

  localparam logic [35:0] D0 = 36'h123456789;
  localparam logic [35:0] DA = 36'h0A1A2A3A4;
  localparam logic [35:0] DB = 36'h0B1B2B3B4;
  localparam logic [35:0] DC = 36'h0C1C2C3C4;
  localparam logic [35:0] DD = 36'h0D1D2D3D4;
  localparam logic [35:0] DM = 36'hABCDEF012;
  localparam logic [35:0] LMASK = 36'h007FC01FF;
  localparam logic [35:0] MERGED = (DM & LMASK) | (D0 & ~LMASK);
  localparam logic [35:0] X2 = 36'h5A5A5A5A5;

  localparam vec_t TBL [14] = '{
    '{1'b0, 1'b0, 1'b1, 4'h0, 6'd4,  36'h0,         1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4,  D0,            1'b1, D0},
    '{1'b0, 1'b0, 1'b1, 4'h0, 6'd10, 36'h0,         1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  DA,            1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  DB,            1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  DC,            1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd11, DD,            1'b1, DB},
    '{1'b1, 1'b0, 1'b1, 4'hF, 6'd0,  36'h0,         1'b1, DC},
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0,         1'b1, DD},
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0,         1'b1, DA},
    '{1'b0, 1'b0, 1'b1, 4'hA, 6'd4,  36'h0,         1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4,  DM,            1'b1, MERGED},
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd4,  36'h0,         1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b1, 4'h0, 6'd4,  36'hFFFFFFFFF, 1'b0, 36'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n, stall, sleep, load_n, write_n, sel_a_n, sel_b, sel_c_n, drive_n;
  logic [3:0]  lane_wr_n;
  logic [5:0]  addr;
  logic [35:0] wdata, rdata;
  logic        rdata_en;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fts_sram dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep),
    .load_n(load_n), .write_n(write_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .lane_wr_n(lane_wr_n), .drive_n(drive_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  task automatic check(input string req, input logic exp_en, input logic [35:0] exp_d);
    checks++;
    if (rdata_en !== exp_en || (exp_en && rdata !== exp_d)) begin
      errors++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               req, rdata_en, rdata, exp_en, exp_d);
    end
  endtask

  task automatic drive(input logic ld, input logic wr, input logic [3:0] bw,
                       input logic [5:0] a, input logic [35:0] d);
    load_n = ld; write_n = wr; lane_wr_n = bw; addr = a; wdata = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; sleep = 1'b0; drive_n = 1'b0;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    drive(1'b1, 1'b1, 4'hF, 6'd0, 36'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 reset idle", 1'b0, 36'h0);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 14; i++) begin
      drive(TBL[i].load_n, TBL[i].write_n, TBL[i].bw_n, TBL[i].addr, TBL[i].wdata);
      sel_b = TBL[i].sel;
      step();
      check($sformatf("R2/R3/R4/R5/R6/R7 row %0d", i), TBL[i].exp_en, TBL[i].exp_d);
    end
    sel_b = 1'b1;

    // R2 read again; R10 drive gating
    drive(1'b0, 1'b1, 4'hF, 6'd4, 36'h0);
    step();
    check("R2 read merged word", 1'b1, MERGED);
    drive_n = 1'b1; #1;
    check("R10 drive_n high", 1'b0, 36'h0);
    drive_n = 1'b0; #1;
    check("R10 state kept", 1'b1, MERGED);

    // R8 stall ignores a new read load
    stall = 1'b1;
    drive(1'b0, 1'b1, 4'hF, 6'd11, 36'h0);
    step();
    check("R8 stall holds read", 1'b1, MERGED);

    // R8 stall between write address and its data
    stall = 1'b0;
    drive(1'b0, 1'b0, 4'h0, 6'd20, 36'h0);
    step();
    check("R3 write loaded", 1'b0, 36'h0);
    stall = 1'b1;
    drive(1'b0, 1'b1, 4'hF, 6'd20, 36'h111111111);
    step();
    check("R8 stalled write", 1'b0, 36'h0);
    stall = 1'b0;
    drive(1'b0, 1'b1, 4'hF, 6'd20, X2);
    step();
    check("R8 R3 commit after stall", 1'b1, X2);

    // R9 sleep
    sleep = 1'b1; #1;
    check("R9 sleep drops drive", 1'b0, 36'h0);
    drive(1'b0, 1'b0, 4'h0, 6'd20, 36'h0);
    step();
    drive(1'b0, 1'b0, 4'h0, 6'd20, 36'hFEDCBA987);
    step();
    check("R9 sleep still quiet", 1'b0, 36'h0);
    drive(1'b0, 1'b1, 4'hF, 6'd20, 36'h0);
    sleep = 1'b0; #1;
    check("R9 state held across sleep", 1'b1, X2);
    step();
    check("R9 contents retained", 1'b1, X2);

    // R7 deselected write does not store
    sel_c_n = 1'b1;
    drive(1'b0, 1'b0, 4'h0, 6'd20, 36'h0);
    step();
    check("R7 deselect write", 1'b0, 36'h0);
    sel_c_n = 1'b0;
    drive(1'b0, 1'b1, 4'hF, 6'd20, 36'h0F0F0F0F0);
    step();
    check("R7 no store on deselect", 1'b1, X2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule